// File: doc/BRIEF.md
# Channel Fault Qualifier and Sticky Fault Register

This block qualifies raw fault indications from the eight channels of a switched output driver. It turns them into a byte of sticky fault flags, and the serial interface loads that byte in parallel. Each channel supplies three raw indications: open load, shorted load and over-temperature. It also supplies its commanded on/off state. An open load is only meaningful while the channel is off, and a short is only meaningful while it is on. The block gates each indication by the command before it filters it.

Each channel has two filters. Open and short conditions share a longer duration filter. Over-temperature goes through a separate, shorter filter and never passes through the open/short filter. Both filters count only unbroken runs of their condition, so any dropout restarts the count. When a filter completes its count, the channel's bit in the fault register sets, and it stays set until the serial interface pulses the clear strobe. The clear also restarts both filters. A condition that is still present therefore needs a full new filter time before its bit sets again.

Top module: `fault_latch_bank`

## Requirements
- R1: A raw open-load indication is counted only while the channel's command is 0 (off). With the command at 1 it never sets the channel's bit, however long it lasts.
- R2: A raw short-load indication is counted only while the channel's command is 1 (on). With the command at 0 it never sets the channel's bit.
- R3: A qualified open or short condition sampled high on OS_LIMIT consecutive clock edges sets the bit at the OS_LIMIT-th edge. A run of OS_LIMIT-1 edges sets nothing.
- R4: A thermal indication is counted regardless of the command, through its own filter. A run of TH_LIMIT consecutive edges sets the bit at the TH_LIMIT-th edge, and a run of TH_LIMIT-1 edges sets nothing.
- R5: Each filter counts only continuous runs. A single sample with the condition low restarts the count from zero.
- R6: Bit i of `fault_byte` belongs to channel i+1, so bit 0 is channel 1 and bit 7 is channel 8. A value of 1 means open, shorted or overheated. Several bits can be set at the same time.
- R7: A set bit stays set after its condition goes away, until a clear strobe arrives.
- R8: A clear strobe sampled high clears every bit at that edge and restarts all filters. A condition that is still present sets its bit again exactly one filter time (OS_LIMIT or TH_LIMIT edges) after the clear edge.
- R9: If a filter completes its count at the same edge that samples the clear strobe, that channel's bit stays set. The other bits still clear.
- R10: A synchronous active-high reset clears the fault register and all filter counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_strobe | input | 1 | One-cycle clear request from the serial interface |
| cmd_on | input | NCH | Commanded state per channel, 1 = on |
| open_raw | input | NCH | Raw open-load indication per channel |
| short_raw | input | NCH | Raw shorted-load indication per channel |
| hot_raw | input | NCH | Raw over-temperature indication per channel |
| fault_byte | output | NCH | Registered sticky fault flags, bit i = channel i+1 |

## Verification
The hardest situation to reach from the ports is a filter completing its count in exactly the cycle that samples the clear strobe. The bench holds a short on a commanded-on channel for OS_LIMIT-1 edges and raises the strobe for the very next edge. It then checks that this bit survives while a bit latched earlier is cleared. A second hard case is re-latching after a clear while the condition never went away. The bench holds a thermal condition steady across the clear and across a reset, and samples one edge before and exactly at the expected re-latch edge.

// File: rtl/fault_pkg.sv
package fault_pkg;
  // Width able to hold the values 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/dur_filter.sv
module dur_filter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cond,
  output logic hit
);
  import fault_pkg::*;
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] FULL = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !cond) cnt <= '0;
    else if (cnt != FULL)        cnt <= cnt + 1'b1;
  end

  // One-cycle pulse when the run reaches the required length
  assign hit = cond && (cnt == LAST);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);
  assert_dropout_restart_R5: assert property (@(posedge clk) disable iff (rst)
    !cond |=> (cnt == '0));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart) |=> !hit);
endmodule

// File: rtl/chan_qual.sv
module chan_qual #(
  parameter int unsigned OS_LIMIT = 10000,
  parameter int unsigned TH_LIMIT = 2250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cmd_on,
  input  logic open_raw,
  input  logic short_raw,
  input  logic hot_raw,
  output logic qual
);
  logic os_cond, os_hit, th_hit;

  // Open counts while off, short counts while on
  assign os_cond = cmd_on ? short_raw : open_raw;

  dur_filter #(.LIMIT(OS_LIMIT)) u_os (
    .clk(clk), .rst(rst), .restart(restart), .cond(os_cond), .hit(os_hit));

  dur_filter #(.LIMIT(TH_LIMIT)) u_th (
    .clk(clk), .rst(rst), .restart(restart), .cond(hot_raw), .hit(th_hit));

  assign qual = os_hit | th_hit;

  assert_open_gated_R1: assert property (@(posedge clk) disable iff (rst)
    (os_hit && !cmd_on) |-> open_raw);
  assert_short_gated_R2: assert property (@(posedge clk) disable iff (rst)
    (os_hit && cmd_on) |-> short_raw);
  assert_thermal_source_R4: assert property (@(posedge clk) disable iff (rst)
    th_hit |-> hot_raw);
endmodule

// File: rtl/fault_latch_bank.sv
module fault_latch_bank #(
  parameter int unsigned NCH      = 8,
  parameter int unsigned OS_LIMIT = 10000,
  parameter int unsigned TH_LIMIT = 2250
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_strobe,
  input  logic [NCH-1:0] cmd_on,
  input  logic [NCH-1:0] open_raw,
  input  logic [NCH-1:0] short_raw,
  input  logic [NCH-1:0] hot_raw,
  output logic [NCH-1:0] fault_byte
);
  logic [NCH-1:0] qual;
  logic [NCH-1:0] fault_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_qual #(.OS_LIMIT(OS_LIMIT), .TH_LIMIT(TH_LIMIT)) u_ch (
      .clk(clk), .rst(rst), .restart(clr_strobe), .cmd_on(cmd_on[i]),
      .open_raw(open_raw[i]), .short_raw(short_raw[i]), .hot_raw(hot_raw[i]),
      .qual(qual[i]));

    // New qualification outranks the clear
    always_ff @(posedge clk) begin
      if (rst)             fault_q[i] <= 1'b0;
      else if (qual[i])    fault_q[i] <= 1'b1;
      else if (clr_strobe) fault_q[i] <= 1'b0;
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (fault_q[i] && !clr_strobe) |=> fault_q[i]);
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (clr_strobe && !qual[i]) |=> !fault_q[i]);
    assert_qual_wins_R9: assert property (@(posedge clk) disable iff (rst)
      qual[i] |=> fault_q[i]);
  end

  assign fault_byte = fault_q;

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (fault_q == '0));
endmodule

// File: tb/fault_latch_bank_bench.sv
module fault_latch_bank_bench;
  localparam int OSL = 40;
  localparam int THL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_strobe = 1'b0;
  logic [7:0] cmd_on = '0, open_raw = '0, short_raw = '0, hot_raw = '0;
  logic [7:0] fault_byte;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fault_latch_bank #(.NCH(8), .OS_LIMIT(OSL), .TH_LIMIT(THL)) u_fault_latch_bank (
    .clk(clk), .rst(rst), .clr_strobe(clr_strobe), .cmd_on(cmd_on),
    .open_raw(open_raw), .short_raw(short_raw), .hot_raw(hot_raw),
    .fault_byte(fault_byte));

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (fault_byte !== exp) begin
      fails++;
      $display("FAIL %s: fault_byte=%h expected=%h", tag, fault_byte, exp);
    end
  endtask

  task automatic pulse_clear();
    clr_strobe = 1'b1;
    tick(1);
    clr_strobe = 1'b0;
  endtask

  task automatic quiet();
    open_raw = '0; short_raw = '0; hot_raw = '0; cmd_on = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R10 reset state", 8'h00);
  endtask

  task automatic t_open_off();
    open_raw[0] = 1'b1;
    tick(OSL - 1);
    check("R3 open one edge short of limit", 8'h00);
    tick(1);
    check("R1 R3 R6 open latched on channel 1 bit 0", 8'h01);
    quiet();
    pulse_clear();
    check("R8 clear with condition gone", 8'h00);
  endtask

  task automatic t_cmd_gating();
    cmd_on[1] = 1'b1; open_raw[1] = 1'b1;
    cmd_on[2] = 1'b1; short_raw[2] = 1'b1;
    short_raw[3] = 1'b1;
    tick(OSL);
    check("R1 R2 only short while on latches", 8'h04);
    tick(2 * OSL);
    check("R1 R2 gated indications still ignored", 8'h04);
    quiet();
    pulse_clear();
    check("R8 clear after gating test", 8'h00);
  endtask

  task automatic t_dropout();
    cmd_on[4] = 1'b1;
    for (int r = 0; r < 3; r++) begin
      short_raw[4] = 1'b1;
      tick(OSL - 1);
      short_raw[4] = 1'b0;
      tick(1);
    end
    check("R3 R5 broken short runs never latch", 8'h00);
    hot_raw[7] = 1'b1;
    tick(THL - 1);
    hot_raw[7] = 1'b0;
    tick(1);
    hot_raw[7] = 1'b1;
    tick(THL - 1);
    check("R4 R5 thermal run restarted by dropout", 8'h00);
    tick(1);
    check("R4 thermal latched on channel 8 bit 7", 8'h80);
    quiet();
    pulse_clear();
    check("R8 clear after thermal", 8'h00);
  endtask

  task automatic t_thermal_indep();
    cmd_on[3] = 1'b1; hot_raw[3] = 1'b1;
    hot_raw[5] = 1'b1;
    tick(THL);
    check("R4 thermal latches whether on or off, short filter", 8'h28);
    quiet();
    pulse_clear();
  endtask

  task automatic t_multi_sticky();
    open_raw[0] = 1'b1;
    cmd_on[5] = 1'b1; short_raw[5] = 1'b1;
    tick(OSL);
    check("R6 two channels latched together", 8'h21);
    quiet();
    tick(25);
    check("R7 bits held after conditions vanish", 8'h21);
  endtask

  task automatic t_race();
    cmd_on[2] = 1'b1; short_raw[2] = 1'b1;
    tick(OSL - 1);
    clr_strobe = 1'b1;
    tick(1);
    clr_strobe = 1'b0;
    check("R9 qualification beats clear, others cleared", 8'h04);
    quiet();
    pulse_clear();
    check("R8 clear after race", 8'h00);
  endtask

  task automatic t_relatch();
    hot_raw[6] = 1'b1;
    tick(THL);
    check("R4 thermal channel 7 latched", 8'h40);
    pulse_clear();
    check("R8 persistent condition cleared at strobe", 8'h00);
    tick(THL - 1);
    check("R8 no relatch before full filter time", 8'h00);
    tick(1);
    check("R8 relatch after full filter time", 8'h40);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R10 reset clears latched bit", 8'h00);
    tick(THL - 1);
    check("R10 reset restarted filter", 8'h00);
    tick(1);
    check("R10 relatch after reset", 8'h40);
    quiet();
    pulse_clear();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    tick(1);
    t_reset();
    t_open_off();
    t_cmd_gating();
    t_dropout();
    t_thermal_indep();
    t_multi_sticky();
    t_race();
    t_relatch();
    finish_run();
  end
endmodule